// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block is a time-division switch with two ports, A and B. Each port has a group of input streams and a group of output streams. A frame is `NUM_CH` channel slots long, and one slot passes per clock. The block stores every byte that arrives in a frame. It then builds each output channel from its own connection-memory word. A word either names a source port, stream and channel, or it carries a literal byte that is sent in message mode. Every byte leaves exactly two frames after it arrived, whatever the source and destination slot numbers are.

Each output channel also carries its own enable and force-high flags. Four controls decide whether an output drives, in a fixed order of precedence:

- reset, together with a per-port strap input;
- an external drive-enable pin;
- a global standby register bit;
- the per-channel enable flag.

A host port reaches the registers and memories through a request/acknowledge handshake:

- the host can read and write both connection memories;
- the host can only read the two data memories;
- one register value can be copied into every connection-memory word in a timed bulk fill, and the fill can be aborted.

Top module: `tsi_switch`

## Requirements
- R1: A byte presented on input port p, stream s, slot c appears on every output channel whose word (enable bit 10 set, bits 9 and 8 clear) selects it. Bit 6 of the word is the port (0 = A, 1 = B), bits 5:4 are the stream and bits 3:0 are the channel. Output slot d is presented on the pins in the cycle after input slot d is sampled.
- R2: A byte that enters in frame N leaves in frame N+2 for every source and destination slot pair. `frame_i` high marks slot 0.
- R3: When word bit 8 (message) is set, the output channel carries word bits 7:0.
- R4: When word bit 10 is clear, the channel's output enable is low. When bit 9 (force-high) is set, the channel drives 0xFF, and this takes precedence over message mode.
- R5: Output-enable precedence, from highest to lowest: reset, then `ode_i` low (all outputs off), then the standby bit (control register bit 0, all outputs off from the next slot), then the per-channel flags.
- R6: While `rst_ni` is low, the outputs of port p are disabled if `rst_hiz_i[p]` is 1. If it is 0, they drive 0xFF.
- R7: Writing bit 3 of the control register (address 0) from 0 to 1 copies the fill register (address 1) into every connection word over `NUM_CH` cycles. Bit 3 then reads back 0.
- R8: Writing bit 3 to 0 while a fill is running stops the fill. Words already filled keep the new value and the rest keep their old value.
- R9: The select field, control bits 2:1, chooses the target of memory addresses (address bit 6 = 1, bits 5:4 stream, bits 3:0 channel). Value 0 selects connection memory A and 1 selects connection memory B; both can be read and written. Value 2 selects data memory A and 3 selects data memory B; both are read-only and return the byte captured in the previous frame.
- R10: `host_ack_o` is a one-cycle pulse. A register access is acknowledged on the cycle after the request. A connection-memory access is held off while a fill is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one channel slot per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Marks slot 0 of a frame |
| ode_i | input | 1 | Output drive enable; low disables all outputs |
| rst_hiz_i | input | 2 | Per-port output state during reset (1 = disabled) |
| din_i | input | 2*NUM_STREAMS*8 | Input bytes, [port][stream] |
| dout_o | output | 2*NUM_STREAMS*8 | Output bytes, [port][stream] |
| doe_o | output | 2*NUM_STREAMS | Output enables, [port][stream] |
| host_req_i | input | 1 | Host request, held until acknowledged |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | 1+log2(NUM_STREAMS)+log2(NUM_CH) | Register or memory address |
| host_wdata_i | input | 16 | Host write data |
| host_ack_o | output | 1 | Access completed |
| host_rdata_o | output | 16 | Read data, valid with the acknowledge |

## Verification
The first routing pattern reverses streams and channels and crosses ports. Early output slots therefore read bytes that arrived late in an earlier frame, which separates a true two-frame delay from one frame or three. The input bytes hash the frame number, so an error in bank rotation shows up as a wrong value instead of a coincidental match.

A second pattern mixes disabled, force-high and message channels with switched ones. It separates the per-channel flags and their precedence. Holding the inputs constant over whole frames makes data-memory reads predictable, so the read-only behaviour can be checked.

The bulk fill is run twice: once to completion, with a blocked host read timed against it, and once aborted after one slot. The two runs separate a finished fill from a cut-off one. The drive-enable tests stack reset, the pin and the standby bit against fully enabled channels.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [1:0] {
    SEL_CM_A = 2'd0,
    SEL_CM_B = 2'd1,
    SEL_DM_A = 2'd2,
    SEL_DM_B = 2'd3
  } mem_sel_e;

  localparam int CTRL_STANDBY = 0;
  localparam int CTRL_SEL_LO  = 1;
  localparam int CTRL_FILL    = 3;
  localparam int NUM_BANKS    = 3;

  function automatic logic [1:0] bank_inc(input logic [1:0] b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction
endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
  import tsi_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  output logic [CW-1:0] slot_o,
  output logic [1:0]    wbank_o,
  output logic [1:0]    rbank_o,
  output logic [1:0]    hbank_o
);
  localparam logic [CW-1:0] LAST = CW'(NUM_CH - 1);

  logic [CW-1:0] ch_q;
  logic [1:0]    bank_q;

  always_comb begin
    slot_o  = (frame_i || ch_q == LAST) ? '0 : ch_q + 1'b1;
    wbank_o = (slot_o == '0) ? bank_inc(bank_q) : bank_q;
    rbank_o = bank_inc(wbank_o);   // frame N-2
    hbank_o = bank_inc(rbank_o);   // frame N-1
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q   <= LAST;
      bank_q <= 2'd2;
    end else begin
      ch_q   <= slot_o;
      bank_q <= wbank_o;
    end
  end
endmodule

// File: rtl/tsi_data_store.sv
module tsi_data_store
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CH      = 16,
  localparam int SW    = $clog2(NUM_STREAMS),
  localparam int CW    = $clog2(NUM_CH),
  localparam int SRC_W = 1 + SW + CW
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [1:0]                           wbank_i,
  input  logic [1:0]                           rbank_i,
  input  logic [1:0]                           hbank_i,
  input  logic [CW-1:0]                        slot_i,
  input  logic [1:0][NUM_STREAMS-1:0][7:0]     din_i,
  input  logic [1:0][NUM_STREAMS-1:0][SRC_W-1:0] sw_addr_i,
  output logic [1:0][NUM_STREAMS-1:0][7:0]     sw_data_o,
  input  logic                                 host_port_i,
  input  logic [SW+CW-1:0]                     host_idx_i,
  output logic [7:0]                           host_data_o
);
  logic [7:0] mem_q [NUM_BANKS][2][NUM_STREAMS][NUM_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < NUM_STREAMS; s++)
            for (int c = 0; c < NUM_CH; c++)
              mem_q[b][p][s][c] <= '0;
    end else begin
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < NUM_STREAMS; s++)
          mem_q[wbank_i][p][s][slot_i] <= din_i[p][s];
    end
  end

  always_comb begin
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < NUM_STREAMS; s++)
        sw_data_o[p][s] = mem_q[rbank_i][sw_addr_i[p][s][SRC_W-1]]
                               [sw_addr_i[p][s][SW+CW-1:CW]][sw_addr_i[p][s][CW-1:0]];
    host_data_o = mem_q[hbank_i][host_port_i][host_idx_i[SW+CW-1:CW]][host_idx_i[CW-1:0]];
  end
endmodule

// File: rtl/tsi_conn_ctrl.sv
module tsi_conn_ctrl
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CH      = 16,
  parameter int WORD_W      = 11,
  localparam int SW  = $clog2(NUM_STREAMS),
  localparam int CW  = $clog2(NUM_CH),
  localparam int HAW = 1 + SW + CW
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   req_i,
  input  logic                                   we_i,
  input  logic [HAW-1:0]                         addr_i,
  input  logic [15:0]                            wdata_i,
  output logic                                   ack_o,
  output logic [15:0]                            rdata_o,
  input  logic [CW-1:0]                          slot_i,
  output logic [1:0][NUM_STREAMS-1:0][WORD_W-1:0] cm_word_o,
  output logic                                   standby_o,
  output logic [1:0]                             mem_sel_o,
  output logic                                   fill_busy_o,
  input  logic [7:0]                             dm_data_i
);
  localparam logic [CW-1:0] LAST = CW'(NUM_CH - 1);

  logic [WORD_W-1:0] cm_q [2][NUM_STREAMS][NUM_CH];
  logic [WORD_W-1:0] fill_val_q;
  logic [CW-1:0]     fill_cnt_q;
  logic              fill_busy_q, standby_q, ack_q;
  logic [1:0]        mem_sel_q;
  logic [15:0]       rdata_q, rd_val;
  logic              is_mem, cm_sel, blocked, fire, ctrl_wr;
  logic [SW-1:0]     s_idx;
  logic [CW-1:0]     c_idx;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[15:WORD_W];
  assign is_mem  = addr_i[HAW-1];
  assign s_idx   = addr_i[SW+CW-1:CW];
  assign c_idx   = addr_i[CW-1:0];
  assign cm_sel  = !mem_sel_q[1];
  assign blocked = is_mem && cm_sel && fill_busy_q;
  assign fire    = req_i && !ack_q && !blocked;
  assign ctrl_wr = fire && we_i && !is_mem && !addr_i[0];

  always_comb begin
    if (!is_mem)
      rd_val = addr_i[0] ? 16'(fill_val_q)
                         : 16'({fill_busy_q, mem_sel_q, standby_q});
    else if (cm_sel)
      rd_val = 16'(cm_q[mem_sel_q[0]][s_idx][c_idx]);
    else
      rd_val = 16'(dm_data_i);
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < NUM_STREAMS; s++)
        cm_word_o[p][s] = cm_q[p][s][slot_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < NUM_STREAMS; s++)
          for (int c = 0; c < NUM_CH; c++)
            cm_q[p][s][c] <= '0;
      fill_val_q  <= '0;
      fill_cnt_q  <= '0;
      fill_busy_q <= 1'b0;
      standby_q   <= 1'b0;
      mem_sel_q   <= SEL_CM_A;
      ack_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      ack_q <= fire;
      if (fire && !we_i) rdata_q <= rd_val;
      if (ctrl_wr) begin
        standby_q <= wdata_i[CTRL_STANDBY];
        mem_sel_q <= wdata_i[CTRL_SEL_LO +: 2];
        if (!wdata_i[CTRL_FILL]) begin
          fill_busy_q <= 1'b0;                 // abort
        end else if (!fill_busy_q) begin
          fill_busy_q <= 1'b1;
          fill_cnt_q  <= '0;
        end
      end else if (fill_busy_q) begin
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < NUM_STREAMS; s++)
            cm_q[p][s][fill_cnt_q] <= fill_val_q;
        if (fill_cnt_q == LAST) fill_busy_q <= 1'b0;
        fill_cnt_q <= fill_cnt_q + 1'b1;
      end
      if (fire && we_i && !is_mem && addr_i[0]) fill_val_q <= wdata_i[WORD_W-1:0];
      if (fire && we_i && is_mem && cm_sel) cm_q[mem_sel_q[0]][s_idx][c_idx] <= wdata_i[WORD_W-1:0];
    end
  end

  assign ack_o       = ack_q;
  assign rdata_o     = rdata_q;
  assign standby_o   = standby_q;
  assign mem_sel_o   = mem_sel_q;
  assign fill_busy_o = fill_busy_q;
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CH      = 16,
  localparam int SW      = $clog2(NUM_STREAMS),
  localparam int CW      = $clog2(NUM_CH),
  localparam int SRC_W   = 1 + SW + CW,
  localparam int FIELD_W = (SRC_W > 8) ? SRC_W : 8,
  localparam int WORD_W  = FIELD_W + 3,
  localparam int HAW     = 1 + SW + CW
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             frame_i,
  input  logic                             ode_i,
  input  logic [1:0]                       rst_hiz_i,
  input  logic [1:0][NUM_STREAMS-1:0][7:0] din_i,
  output logic [1:0][NUM_STREAMS-1:0][7:0] dout_o,
  output logic [1:0][NUM_STREAMS-1:0]      doe_o,
  input  logic                             host_req_i,
  input  logic                             host_we_i,
  input  logic [HAW-1:0]                   host_addr_i,
  input  logic [15:0]                      host_wdata_i,
  output logic                             host_ack_o,
  output logic [15:0]                      host_rdata_o
);
  localparam int MSG_B = FIELD_W;
  localparam int DH_B  = FIELD_W + 1;
  localparam int EN_B  = FIELD_W + 2;

  logic [CW-1:0] slot;
  logic [1:0]    wbank, rbank, hbank;
  logic          standby, fill_busy;
  logic [1:0]    mem_sel;
  logic [7:0]    dm_host;
  logic [1:0][NUM_STREAMS-1:0][WORD_W-1:0] cm_word;
  logic [1:0][NUM_STREAMS-1:0][SRC_W-1:0]  sw_addr;
  logic [1:0][NUM_STREAMS-1:0][7:0]        sw_data, dout_d, dout_q;
  logic [1:0][NUM_STREAMS-1:0]             doe_d, doe_q;

  tsi_slot_timer #(.NUM_CH(NUM_CH)) timer_i (
    .clk_i, .rst_ni, .frame_i,
    .slot_o(slot), .wbank_o(wbank), .rbank_o(rbank), .hbank_o(hbank)
  );

  tsi_data_store #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH)) store_i (
    .clk_i, .rst_ni,
    .wbank_i(wbank), .rbank_i(rbank), .hbank_i(hbank), .slot_i(slot),
    .din_i, .sw_addr_i(sw_addr), .sw_data_o(sw_data),
    .host_port_i(mem_sel[0]), .host_idx_i(host_addr_i[SW+CW-1:0]),
    .host_data_o(dm_host)
  );

  tsi_conn_ctrl #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH), .WORD_W(WORD_W)) conn_i (
    .clk_i, .rst_ni,
    .req_i(host_req_i), .we_i(host_we_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .ack_o(host_ack_o), .rdata_o(host_rdata_o),
    .slot_i(slot), .cm_word_o(cm_word),
    .standby_o(standby), .mem_sel_o(mem_sel), .fill_busy_o(fill_busy),
    .dm_data_i(dm_host)
  );

  always_comb begin
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < NUM_STREAMS; s++) begin
        sw_addr[p][s] = cm_word[p][s][SRC_W-1:0];
        doe_d[p][s]   = 1'b1;
        dout_d[p][s]  = sw_data[p][s];
        if (standby || !cm_word[p][s][EN_B]) begin
          doe_d[p][s]  = 1'b0;
          dout_d[p][s] = 8'hFF;
        end else if (cm_word[p][s][DH_B]) begin
          dout_d[p][s] = 8'hFF;
        end else if (cm_word[p][s][MSG_B]) begin
          dout_d[p][s] = cm_word[p][s][7:0];
        end
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      doe_q  <= '0;
      dout_q <= '1;
    end else begin
      doe_q  <= doe_d;
      dout_q <= dout_d;
    end
  end

  // pin-level precedence: reset strap, then drive-enable pin
  always_comb begin
    for (int p = 0; p < 2; p++) begin
      if (!rst_ni) begin
        doe_o[p]  = {NUM_STREAMS{~rst_hiz_i[p]}};
        dout_o[p] = '1;
      end else if (!ode_i) begin
        doe_o[p]  = '0;
        dout_o[p] = dout_q[p];
      end else begin
        doe_o[p]  = doe_q[p];
        dout_o[p] = dout_q[p];
      end
    end
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_CH      = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        ode_i,
  input logic [1:0]                  rst_hiz_i,
  input logic [1:0][NUM_STREAMS-1:0] doe_o,
  input logic                        host_req_i,
  input logic                        mem_flag,
  input logic                        host_ack_o,
  input logic                        standby,
  input logic                        dm_selected,
  input logic                        fill_busy
);
  int unsigned fill_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_run <= 0;
    else         fill_run <= fill_busy ? fill_run + 1 : 0;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_strap_R6: assert (doe_o[0] == {NUM_STREAMS{~rst_hiz_i[0]}} &&
                                     doe_o[1] == {NUM_STREAMS{~rst_hiz_i[1]}});
    end
  end

  assert_ode_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ode_i |-> (doe_o == '0));

  assert_standby_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby |=> (doe_o == '0));

  assert_ack_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |=> !host_ack_o);

  assert_cm_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_busy && host_req_i && mem_flag && !dm_selected) |=> !host_ack_o);

  assert_fill_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_run <= NUM_CH);
endmodule

bind tsi_switch tsi_switch_chk #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ode_i(ode_i), .rst_hiz_i(rst_hiz_i), .doe_o(doe_o),
  .host_req_i(host_req_i), .mem_flag(host_addr_i[HAW-1]), .host_ack_o(host_ack_o),
  .standby(standby), .dm_selected(mem_sel[1]), .fill_busy(fill_busy)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb_top;
  localparam int NS = 4, NCH = 16;

  logic clk = 0, rst_n = 0, frame = 0, ode = 1;
  logic [1:0] rst_hiz = 2'b01;
  logic [1:0][NS-1:0][7:0] din = '0;
  logic [1:0][NS-1:0][7:0] dout;
  logic [1:0][NS-1:0] doe;
  logic req = 0, we = 0, ack;
  logic [6:0] addr = '0;
  logic [15:0] wdata = '0, rdata;

  int n_chk = 0, n_fail = 0;
  int drv_slot = 0, drv_frame = 0;
  bit const_mode = 0;
  logic [10:0] mcm [2][NS][NCH];

  always #10 clk = ~clk;

  tsi_switch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .ode_i(ode), .rst_hiz_i(rst_hiz),
    .din_i(din), .dout_o(dout), .doe_o(doe),
    .host_req_i(req), .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_ack_o(ack), .host_rdata_o(rdata)
  );

  function automatic int pat(int f, int p, int s, int c);
    if (const_mode) return p * 64 + s * 16 + c;
    return (f * 73 + p * 151 + s * 29 + c * 11) & 255;
  endfunction

  task automatic chk(bit ok, string req_tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  // stream driver: one slot per cycle, slot 0 flagged
  initial begin
    int nxt_slot = 0, nxt_frame = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        drv_slot  = nxt_slot;
        drv_frame = nxt_frame;
        frame = (nxt_slot == 0);
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < NS; s++)
            din[p][s] = 8'(pat(nxt_frame, p, s, nxt_slot));
        nxt_slot++;
        if (nxt_slot == NCH) begin nxt_slot = 0; nxt_frame++; end
      end
    end
  end

  task automatic host_wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    while (!ack) @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic host_rd(input logic [6:0] a, output logic [15:0] d, output int waited);
    @(negedge clk);
    req = 1; we = 0; addr = a; waited = 1;
    @(negedge clk);
    while (!ack) begin @(negedge clk); waited++; end
    d = rdata; req = 0;
  endtask

  function automatic logic [6:0] maddr(int s, int c);
    return {1'b1, 2'(s), 4'(c)};
  endfunction

  task automatic cm_write(int p, int s, int c, logic [10:0] w);
    host_wr(7'd0, 16'(p << 1));          // select connection memory of port p
    host_wr(maddr(s, c), 16'(w));
    mcm[p][s][c] = w;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check_frame(string tag);
    @(posedge clk); #2;
    while (drv_slot != 0) begin @(posedge clk); #2; end
    for (int k = 0; k < NCH; k++) begin
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < NS; s++) begin
          logic [10:0] w = mcm[p][s][k];
          int ed;
          if (!w[10]) begin
            chk(doe[p][s] == 0, tag, $sformatf("oe p%0d s%0d c%0d", p, s, k), doe[p][s], 0);
          end else begin
            if (w[9]) ed = 255;
            else if (w[8]) ed = w[7:0];
            else ed = pat(drv_frame - 2, w[6], w[5:4], w[3:0]);
            chk(doe[p][s] == 1 && dout[p][s] == 8'(ed), tag,
                $sformatf("data p%0d s%0d c%0d", p, s, k), {doe[p][s], dout[p][s]}, 256 + ed);
          end
        end
      @(posedge clk); #2;
    end
  endtask

  task automatic t_reset;  // R6
    #5;
    chk(doe[0] == 0, "R6", "port A hiz in reset", doe[0], 0);
    chk(doe[1] == '1 && dout[1] == '1, "R6", "port B high in reset", doe[1], 15);
    rst_hiz = 2'b10; #1;
    chk(doe[0] == '1 && dout[0] == '1 && doe[1] == 0, "R6", "strap swap", {doe[1], doe[0]}, 8'h0F);
    @(posedge clk); #5; rst_n = 1;
  endtask

  task automatic t_all_disabled;  // R4
    wait_cycles(3 * NCH);
    check_frame("R4 reset words disabled");
  endtask

  task automatic t_permute;  // R1 R2
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NCH; c++) begin
        cm_write(0, s, c, 11'h400 | 11'(1 << 6) | 11'((NS - 1 - s) << 4) | 11'(NCH - 1 - c));
        cm_write(1, s, c, 11'h400 | 11'(s << 4) | 11'(c));
      end
    wait_cycles(NCH);
    check_frame("R1 R2 reversed routing");
    check_frame("R2 second frame");
  endtask

  task automatic t_channel_flags;  // R3 R4
    cm_write(0, 0, 3, 11'h000);
    cm_write(0, 1, 7, 11'h700 | 11'h12);
    cm_write(0, 2, 9, 11'h500 | 11'hA5);
    cm_write(1, 3, 0, 11'h500);
    check_frame("R3 R4 per-channel flags");
  endtask

  task automatic t_mem_select;  // R9
    logic [15:0] d; int w;
    const_mode = 1;
    wait_cycles(3 * NCH);
    host_wr(7'd0, 16'(2 << 1));
    host_rd(maddr(1, 5), d, w);
    chk(d == 16'(pat(0, 0, 1, 5)), "R9", "data mem A read", d, pat(0, 0, 1, 5));
    host_wr(maddr(1, 5), 16'h00EE);
    host_rd(maddr(1, 5), d, w);
    chk(d == 16'(pat(0, 0, 1, 5)), "R9", "data mem write ignored", d, pat(0, 0, 1, 5));
    host_wr(7'd0, 16'(3 << 1));
    host_rd(maddr(2, 14), d, w);
    chk(d == 16'(pat(0, 1, 2, 14)), "R9", "data mem B read", d, pat(0, 1, 2, 14));
    host_wr(7'd0, 16'(1 << 1));
    host_rd(maddr(3, 0), d, w);
    chk(d == 16'(mcm[1][3][0]), "R9", "conn mem B read", d, mcm[1][3][0]);
    host_wr(7'd0, 16'(0));
    host_rd(maddr(2, 9), d, w);
    chk(d == 16'(mcm[0][2][9]), "R9", "conn mem A read", d, mcm[0][2][9]);
    cm_write(1, 2, 2, 11'h533);
    host_rd(maddr(2, 2), d, w);
    chk(d == 16'h0533, "R9", "conn mem B write", d, 16'h0533);
  endtask

  task automatic t_fill;  // R7 R10
    logic [15:0] d; int w;
    host_wr(7'd1, 16'h055A);
    host_rd(7'd0, d, w);
    chk(w == 1, "R10", "register ack delay", w, 1);
    host_wr(7'd0, 16'h0008);
    host_rd(maddr(2, 7), d, w);
    chk(w >= NCH - 2, "R10", "conn access held during fill", w, NCH - 2);
    chk(d == 16'h055A, "R7", "filled word", d, 16'h055A);
    host_rd(7'd0, d, w);
    chk(d[3] == 0, "R7", "fill bit self-clears", d[3], 0);
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < NS; s++)
        for (int c = 0; c < NCH; c++) mcm[p][s][c] = 11'h55A;
    check_frame("R7 outputs after fill");
  endtask

  task automatic t_abort;  // R8
    logic [15:0] d; int w;
    host_wr(7'd1, 16'h0577);
    host_wr(7'd0, 16'h0008);
    host_wr(7'd0, 16'h0000);
    host_rd(7'd0, d, w);
    chk(d[3] == 0, "R8", "fill bit after abort", d[3], 0);
    host_rd(maddr(0, 0), d, w);
    chk(d == 16'h0577, "R8", "first slot filled", d, 16'h0577);
    host_rd(maddr(3, NCH - 1), d, w);
    chk(d == 16'h055A, "R8", "last slot untouched", d, 16'h055A);
  endtask

  task automatic t_priority;  // R5
    host_wr(7'd1, 16'h053C);
    host_wr(7'd0, 16'h0008);
    wait_cycles(NCH + 4);
    @(negedge clk);
    chk(doe == '1 && dout[1][2] == 8'h3C, "R5", "all enabled baseline", doe, 8'hFF);
    ode = 0; #1;
    chk(doe == '0, "R5", "drive-enable pin off", doe, 0);
    ode = 1;
    host_wr(7'd0, 16'h0001);
    wait_cycles(2); @(negedge clk);
    chk(doe == '0, "R5", "standby off", doe, 0);
    host_wr(7'd0, 16'h0000);
    wait_cycles(2); @(negedge clk);
    chk(doe == '1, "R5", "standby cleared", doe, 8'hFF);
    ode = 0; rst_hiz = 2'b00; rst_n = 0; #1;
    chk(doe == '1 && dout == '1, "R5", "reset over drive-enable pin", doe, 8'hFF);
  endtask

  initial begin
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < NS; s++)
        for (int c = 0; c < NCH; c++) mcm[p][s][c] = '0;
    t_reset();
    t_all_disabled();
    t_permute();
    t_channel_flags();
    t_mem_select();
    t_fill();
    t_abort();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule